// File: doc/BRIEF.md
# Oversampled Asynchronous Character Receiver

This block turns an asynchronous serial line into parallel characters. A tick input runs at sixteen times the bit rate and drives all timing. An idle-to-low transition of the line opens a frame. The start bit is checked again at its centre so that short glitches are rejected. Each following bit is then decided by a three-sample vote at its centre. The finished character goes into a read register, together with status flags for framing, parity, noise and overrun.

A line-idle detector and a receiver-active output help the surrounding logic find message boundaries. An input selector can cut the receiver off from its pin and feed it either from the internal transmitter output or from the transmit pin, which allows loopback testing. A pulse on the read input stands for a read of the data register and clears the per-character flags.

Top module: `async_char_rx`

## Requirements
- R1: The line, after synchronisation, is sampled on each tick. A high-to-low change opens a frame and counts as tick phase 0. At phase 8 the line is sampled once more. If it is high there, the frame is dropped and no character is stored.
- R2: Data bits follow the start bit at 16-tick spacing, least significant bit first. In 8-bit mode 8 bits are captured and `rx_data[8]` reads 0. In 9-bit mode 9 bits are captured into `rx_data[8:0]`.
- R3: Each data bit and the stop bit is sampled at phases 7, 8 and 9 of its bit period and decided by a two-of-three majority. If the three samples of any bit in the frame disagree, `noise_flag` is set for that character.
- R4: The stop bit follows the last data bit and is decided the same way. A decided value of 0 sets `frame_err`, and the character is still stored.
- R5: When `par_en` is 1, the last captured bit (bit 7 or bit 8) is the parity bit. `par_err` is set when the XOR of all captured bits differs from `par_odd` (0 means even, 1 means odd).
- R6: When a frame completes and `rx_full` is 0, the character and its flags are loaded and `rx_full` goes to 1. A one-cycle `rd_strobe` clears `rx_full`, `overrun`, `noise_flag`, `frame_err` and `par_err`.
- R7: A frame that completes while `rx_full` is 1 and no read happens in that cycle sets `overrun`. That frame is discarded, and `rx_data` and the other character flags keep their values.
- R8: `idle_flag` sets once the line has stayed high for a whole character time: 16 x (bits + 2) ticks. With `idle_after_stop` at 0, the count runs during a frame, starting after the start bit. With it at 1, the count starts only after the stop bit. A low line sample clears both the count and the flag.
- R9: `rx_active` is 1 from the cycle after start detection until the stop-bit decision, or until a start is rejected.
- R10: With `loop_en` at 0 the receiver listens to `rxd_pin`. With `loop_en` at 1, `rxd_pin` is ignored and `loop_src` selects `tx_internal` (0) or `txd_pin` (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 16x bit-rate enable |
| rxd_pin | input | 1 | Receive pin |
| tx_internal | input | 1 | Internal transmitter output, loopback source 0 |
| txd_pin | input | 1 | Transmit pin level, loopback source 1 |
| loop_en | input | 1 | Disconnect receiver from rxd_pin |
| loop_src | input | 1 | Loopback source select |
| nine_bit | input | 1 | 1 selects 9 data bits |
| par_en | input | 1 | Parity check enable |
| par_odd | input | 1 | 1 selects odd parity |
| idle_after_stop | input | 1 | Idle count starts after stop bit |
| rd_strobe | input | 1 | Data register read pulse |
| rx_data | output | 9 | Received character |
| rx_full | output | 1 | Character waiting |
| overrun | output | 1 | Character lost |
| noise_flag | output | 1 | Sample disagreement seen |
| frame_err | output | 1 | Stop bit was 0 |
| par_err | output | 1 | Parity mismatch |
| idle_flag | output | 1 | Line idle for one character time |
| rx_active | output | 1 | Frame in progress |

## Verification
The bench drives a short spike on an idle line. A receiver that skipped the mid-bit start check would then store a bogus character. It places a one-cycle glitch exactly on the centre sample of a data bit. A design without the vote would flip that bit, and one without the flag would stay silent about it. It sends a second frame without reading the first, to catch a design that overwrites the stored character. It also runs the idle count in both start modes, with a timing window that only the correct starting point satisfies. Finally, it holds the pin low while in loopback, which exposes a selector that still listens to the pin.

// File: rtl/acr_pkg.sv
package acr_pkg;
  typedef enum logic [1:0] {
    RX_WAIT  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/acr_line_sel.sv
module acr_line_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rxd_pin,
  input  logic tx_internal,
  input  logic txd_pin,
  input  logic loop_en,
  input  logic loop_src,
  output logic line
);
  logic picked;

  always_comb begin
    if (!loop_en)      picked = rxd_pin;
    else if (loop_src) picked = txd_pin;
    else               picked = tx_internal;
  end

  generate
    if (SYNC_STAGES <= 1) begin : g_one
      logic stage_q;
      always_ff @(posedge clk) begin
        if (rst) stage_q <= 1'b1;
        else     stage_q <= picked;
      end
      assign line = stage_q;
    end else begin : g_chain
      logic [SYNC_STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[SYNC_STAGES-2:0], picked};
      end
      assign line = chain_q[SYNC_STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/acr_vote.sv
module acr_vote #(
  parameter int OSR = 16,
  localparam int PW = $clog2(OSR)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [PW-1:0] phase,
  input  logic          line,
  output logic          vote,
  output logic          disagree
);
  localparam logic [PW-1:0] PH_EARLY = PW'(OSR / 2 - 1);
  localparam logic [PW-1:0] PH_MID   = PW'(OSR / 2);

  logic early_q, mid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      early_q <= 1'b1;
      mid_q   <= 1'b1;
    end else if (tick) begin
      if (phase == PH_EARLY) early_q <= line;
      if (phase == PH_MID)   mid_q   <= line;
    end
  end

  assign vote     = acr_pkg::maj3(early_q, mid_q, line);
  assign disagree = (early_q != mid_q) || (mid_q != line);
endmodule

// File: rtl/acr_frame.sv
module acr_frame #(
  parameter int OSR    = 16,
  parameter int DATA_W = 9,
  localparam int PW    = $clog2(OSR),
  localparam int IW    = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              line,
  input  logic              nine_bit,
  input  logic              vote,
  input  logic              disagree,
  output logic [PW-1:0]     phase,
  output logic              active,
  output logic              done,
  output logic [DATA_W-1:0] f_data,
  output logic              f_noise,
  output logic              f_stop_bad
);
  import acr_pkg::*;

  localparam logic [PW-1:0] PH_MID  = PW'(OSR / 2);
  localparam logic [PW-1:0] PH_LATE = PW'(OSR / 2 + 1);
  localparam logic [PW-1:0] PH_LAST = PW'(OSR - 1);
  localparam logic [IW-1:0] IDX_LONG  = IW'(DATA_W - 1);
  localparam logic [IW-1:0] IDX_SHORT = IW'(DATA_W - 2);

  rx_state_t         state;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] sh;
  logic              noisy, prev_line, long_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RX_WAIT; phase <= '0; idx <= '0; sh <= '0;
      noisy <= 1'b0; prev_line <= 1'b1; long_q <= 1'b0; done <= 1'b0;
      f_data <= '0; f_noise <= 1'b0; f_stop_bad <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        prev_line <= line;
        unique case (state)
          RX_WAIT: begin
            if (prev_line && !line) begin
              state  <= RX_START;
              phase  <= PW'(1);
              sh     <= '0;
              noisy  <= 1'b0;
              long_q <= nine_bit;
            end
          end
          RX_START: begin
            phase <= phase + PW'(1);
            if (phase == PH_MID && line) state <= RX_WAIT;
            else if (phase == PH_LAST) begin
              state <= RX_BITS;
              idx   <= '0;
            end
          end
          RX_BITS: begin
            phase <= phase + PW'(1);
            if (phase == PH_LATE) begin
              sh[idx] <= vote;
              noisy   <= noisy | disagree;
            end
            if (phase == PH_LAST) begin
              if (idx == (long_q ? IDX_LONG : IDX_SHORT)) state <= RX_STOP;
              else idx <= idx + IW'(1);
            end
          end
          RX_STOP: begin
            phase <= phase + PW'(1);
            if (phase == PH_LATE) begin
              state      <= RX_WAIT;
              done       <= 1'b1;
              f_data     <= sh;
              f_noise    <= noisy | disagree;
              f_stop_bad <= !vote;
            end
          end
          default: state <= RX_WAIT;
        endcase
      end
    end
  end

  assign active = (state != RX_WAIT);

  AST_START_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> !$past(line)); // R1
  AST_DONE_ENDS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    done |-> (!active && $past(active))); // R9
endmodule

// File: rtl/async_char_rx.sv
module async_char_rx #(
  parameter int OSR         = 16,
  parameter int DATA_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rxd_pin,
  input  logic              tx_internal,
  input  logic              txd_pin,
  input  logic              loop_en,
  input  logic              loop_src,
  input  logic              nine_bit,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              idle_after_stop,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              overrun,
  output logic              noise_flag,
  output logic              frame_err,
  output logic              par_err,
  output logic              idle_flag,
  output logic              rx_active
);
  localparam int PW       = $clog2(OSR);
  localparam int IDLE_LONG  = OSR * (DATA_W + 2);
  localparam int IDLE_SHORT = OSR * (DATA_W + 1);
  localparam int CW       = $clog2(IDLE_LONG + 1);

  logic              line, vote, disagree, f_done, f_noise, f_stop_bad;
  logic [PW-1:0]     phase;
  logic [DATA_W-1:0] f_data;
  logic [CW-1:0]     idle_cnt;
  logic [CW-1:0]     idle_lim;
  logic              take, parity_bad;

  acr_line_sel #(.SYNC_STAGES(SYNC_STAGES)) u_sel (
    .clk(clk), .rst(rst), .rxd_pin(rxd_pin), .tx_internal(tx_internal),
    .txd_pin(txd_pin), .loop_en(loop_en), .loop_src(loop_src), .line(line));

  acr_vote #(.OSR(OSR)) u_vote (
    .clk(clk), .rst(rst), .tick(tick), .phase(phase), .line(line),
    .vote(vote), .disagree(disagree));

  acr_frame #(.OSR(OSR), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst(rst), .tick(tick), .line(line), .nine_bit(nine_bit),
    .vote(vote), .disagree(disagree), .phase(phase), .active(rx_active),
    .done(f_done), .f_data(f_data), .f_noise(f_noise), .f_stop_bad(f_stop_bad));

  assign take       = f_done && (!rx_full || rd_strobe);
  assign parity_bad = par_en && ((^f_data) != par_odd);
  assign idle_lim   = nine_bit ? CW'(IDLE_LONG) : CW'(IDLE_SHORT);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data <= '0; rx_full <= 1'b0; overrun <= 1'b0;
      noise_flag <= 1'b0; frame_err <= 1'b0; par_err <= 1'b0;
    end else begin
      if (rd_strobe) begin
        rx_full <= 1'b0; overrun <= 1'b0;
        noise_flag <= 1'b0; frame_err <= 1'b0; par_err <= 1'b0;
      end
      if (take) begin
        rx_data    <= f_data;
        rx_full    <= 1'b1;
        noise_flag <= f_noise;
        frame_err  <= f_stop_bad;
        par_err    <= parity_bad;
      end else if (f_done) begin
        overrun <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_cnt  <= '0;
      idle_flag <= 1'b0;
    end else if (tick) begin
      if (!line) begin
        idle_cnt  <= '0;
        idle_flag <= 1'b0;
      end else if (!idle_after_stop || !rx_active) begin
        if (idle_cnt >= idle_lim - CW'(1)) idle_flag <= 1'b1;
        else idle_cnt <= idle_cnt + CW'(1);
      end
    end
  end

  AST_FULL_FROM_FRAME: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_full) |-> $past(f_done)); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !f_done) |=> (!rx_full && !overrun)); // R6
  AST_OVR_HOLDS_DATA: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $stable(rx_data)); // R7
  AST_IDLE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (rst)
    $rose(idle_flag) |-> $past(line)); // R8
endmodule

// File: tb/async_char_rx_bench.sv
module async_char_rx_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, tick = 1'b0;
  logic rxd_pin = 1'b1, tx_internal = 1'b1, txd_pin = 1'b1;
  logic loop_en = 1'b0, loop_src = 1'b0;
  logic nine_bit = 1'b0, par_en = 1'b0, par_odd = 1'b0, idle_after_stop = 1'b0;
  logic rd_strobe = 1'b0;
  logic [8:0] rx_data;
  logic rx_full, overrun, noise_flag, frame_err, par_err, idle_flag, rx_active;

  async_char_rx u_async_char_rx (
    .clk(clk), .rst(rst), .tick(tick), .rxd_pin(rxd_pin), .tx_internal(tx_internal),
    .txd_pin(txd_pin), .loop_en(loop_en), .loop_src(loop_src), .nine_bit(nine_bit),
    .par_en(par_en), .par_odd(par_odd), .idle_after_stop(idle_after_stop),
    .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_full(rx_full), .overrun(overrun),
    .noise_flag(noise_flag), .frame_err(frame_err), .par_err(par_err),
    .idle_flag(idle_flag), .rx_active(rx_active));

  int n_chk = 0, n_err = 0, route = 0;
  bit finished = 0;

  // {nine, par_en, par_odd, stop, glitch_bit[3:0], bits[8:0]}; glitch 15 = none
  localparam int NV = 7;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 1'b1, 4'hF, 9'h0A5},
    {1'b0, 1'b0, 1'b0, 1'b1, 4'd3, 9'h03C},
    {1'b0, 1'b0, 1'b0, 1'b0, 4'hF, 9'h081},
    {1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 9'h1C3},
    {1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 9'h037},
    {1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 9'h10F},
    {1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 9'h00F}
  };

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put_line(input logic v);
    case (route)
      1: tx_internal = v;
      2: txd_pin = v;
      default: rxd_pin = v;
    endcase
  endtask

  task automatic send_frame(input logic [8:0] bits, input int nb, input logic stopv,
                            input int glitch);
    for (int k = 0; k < nb + 2; k++) begin
      logic v;
      if (k == 0) v = 1'b0;
      else if (k == nb + 1) v = stopv;
      else v = bits[k-1];
      for (int p = 0; p < 16; p++) begin
        @(negedge clk);
        put_line((k == glitch && p == 8) ? ~v : v);
      end
    end
    @(negedge clk);
    put_line(1'b1);
    repeat (4) @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0; tick = 1'b1;
    @(negedge clk);
    chk("R6 reset full", {8'd0, rx_full}, 9'd0);
    chk("R9 reset active", {8'd0, rx_active}, 9'd0);
    chk("R6 reset data", rx_data, 9'd0);

    for (int i = 0; i < NV; i++) begin
      logic [8:0] bits, mask;
      int nb, gl;
      nine_bit = VEC[i][16]; par_en = VEC[i][15]; par_odd = VEC[i][14];
      nb = nine_bit ? 9 : 8;
      mask = nine_bit ? 9'h1FF : 9'h0FF;
      bits = VEC[i][8:0] & mask;
      gl = int'(VEC[i][12:9]);
      send_frame(bits, nb, VEC[i][13], gl);
      chk("R6 full set", {8'd0, rx_full}, 9'd1);
      chk("R2 data", rx_data, bits);
      chk("R3 noise", {8'd0, noise_flag}, {8'd0, gl != 15});
      chk("R4 framing", {8'd0, frame_err}, {8'd0, !VEC[i][13]});
      chk("R5 parity", {8'd0, par_err}, {8'd0, par_en && ((^bits) != par_odd)});
      chk("R9 inactive after", {8'd0, rx_active}, 9'd0);
      do_read();
      chk("R6 read clears", {4'd0, rx_full, overrun, noise_flag, frame_err, par_err}, 9'd0);
      repeat (20) @(negedge clk);
    end
    nine_bit = 1'b0; par_en = 1'b0; par_odd = 1'b0;

    // R9: active during a frame
    fork
      send_frame(9'h055, 8, 1'b1, 15);
      begin
        repeat (40) @(negedge clk);
        chk("R9 active mid", {8'd0, rx_active}, 9'd1);
      end
    join
    do_read();

    // R1: spike rejected
    @(negedge clk); rxd_pin = 1'b0;
    repeat (3) @(negedge clk); rxd_pin = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 spike starts", {8'd0, rx_active}, 9'd1);
    repeat (30) @(negedge clk);
    chk("R1 spike dropped", {7'd0, rx_active, rx_full}, 9'd0);
    send_frame(9'h0E7, 8, 1'b1, 15);
    chk("R1 next frame ok", rx_data, 9'h0E7);
    do_read();

    // R7: overrun keeps first character
    send_frame(9'h012, 8, 1'b1, 15);
    send_frame(9'h0F0, 8, 1'b0, 15);
    chk("R7 overrun set", {8'd0, overrun}, 9'd1);
    chk("R7 data kept", rx_data, 9'h012);
    chk("R7 flags kept", {8'd0, frame_err}, 9'd0);
    do_read();
    chk("R7 read clears", {7'd0, overrun, rx_full}, 9'd0);

    // R10: loopback, pin held low and ignored
    loop_en = 1'b1; loop_src = 1'b0; @(negedge clk);
    rxd_pin = 1'b0; route = 1;
    send_frame(9'h05A, 8, 1'b1, 15);
    chk("R10 internal source", {rx_full, rx_data[7:0]}, 9'h15A);
    do_read();
    loop_src = 1'b1; @(negedge clk);
    tx_internal = 1'b0; route = 2;
    send_frame(9'h0C3, 8, 1'b1, 15);
    chk("R10 pin source", {rx_full, rx_data[7:0]}, 9'h1C3);
    do_read();
    tx_internal = 1'b1; rxd_pin = 1'b1; @(negedge clk);
    loop_en = 1'b0; loop_src = 1'b0; route = 0;
    repeat (10) @(negedge clk);

    // R8: idle count start point
    for (int m = 0; m < 2; m++) begin
      idle_after_stop = (m == 1);
      fork
        send_frame(9'h0FF, 8, 1'b1, 15);
        begin
          repeat (40) @(negedge clk);
          chk("R8 idle cleared by start", {8'd0, idle_flag}, 9'd0);
        end
      join
      repeat (46) @(negedge clk);
      chk("R8 idle early window", {8'd0, idle_flag}, {8'd0, m == 0});
      repeat (150) @(negedge clk);
      chk("R8 idle late", {8'd0, idle_flag}, 9'd1);
      do_read();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule